// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers interrupt request flags from up to sixteen priority levels, each level owning a group of eight flag bits and eight matching enable bits. Every cycle it resolves the highest-numbered level that has an eligible request. It registers the 16-bit word address of that level's vector entry, the level index and a request line for the processor. The processor takes the request by pulsing or holding an acknowledge strobe.

Levels fall into three gating classes:
- The top level is reset-class: its flags request service no matter what any enable says.
- A band of levels just below it is (non)-maskable: a flag there needs its own enable bit, and the global enable has no effect on it.
- All lower levels are maskable: a flag there needs both its own enable bit and the global enable.

The global enable lives inside the block. Software writes it through a write strobe, and an accepted acknowledge clears it. The flags themselves are never cleared here; the peripherals and software own them.

A three-state machine sequences the outputs:
- **ST_IDLE**: no request is shown.
- **ST_PEND**: a request is shown.
- **ST_HOLD**: the processor is acknowledging, and the outputs are frozen.

The machine takes these transitions:
- *raise* (IDLE→PEND): an eligible request appears.
- *drop* (PEND→IDLE): no eligible request remains.
- *take* (PEND→HOLD): the acknowledge is seen while a request is pending.
- *keep* (HOLD→HOLD): the acknowledge stays high.
- *release* (HOLD→IDLE or HOLD→PEND): the acknowledge falls, and the machine re-resolves.

Top module: `pvic_ctrl`

## Requirements
- R1: During and right after reset, irq_o is 0, prio_o is 0, vec_o is 0xFFE0 and gie_o is 0.
- R2: vec_o always equals 0xFFE0 + 2·prio_o, so level 15 gives 0xFFFE and level 0 gives 0xFFE0.
- R3: When several levels have eligible requests, the highest-numbered level is selected. Level 15 is selected over every other level.
- R4: A flag in level 15 (flag_i bits 127..120) raises a request whatever its enable bit and gie_o hold.
- R5: A flag in levels 12..14 raises a request only when its own enable bit is 1. gie_o has no effect on these levels.
- R6: A flag in levels 0..11 raises a request only when its own enable bit and gie_o are both 1.
- R7: Level n requests when any of flag bits 8n..8n+7, ANDed with the same en_i bits, is set. This includes group bits 6 and 7.
- R8: irq_o, vec_o and prio_o are registered. They reflect the flags of the previous clock edge and do not change combinationally.
- R9: An acknowledge seen in ST_PEND clears gie_o at the next edge and drops irq_o. This happens even if gie_wr_i writes a 1 in the same cycle. An acknowledge seen in ST_IDLE changes nothing.
- R10: While ack_i stays high in ST_HOLD, vec_o and prio_o stay stable whatever the flags do. After ack_i falls, the next edge re-resolves.
- R11: With no eligible request, irq_o is 0 and vec_o and prio_o keep their last values.
- R12: A cycle with gie_wr_i = 1 and no accepted acknowledge loads gie_wdata_i into gie_o at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flag_i | input | 128 | Request flags, eight per level, level n at bits 8n..8n+7 |
| en_i | input | 128 | Per-flag enable bits, same layout as flag_i |
| gie_wr_i | input | 1 | Write strobe for the global enable |
| gie_wdata_i | input | 1 | Value written to the global enable |
| ack_i | input | 1 | Acknowledge from the processor |
| irq_o | output | 1 | Interrupt request line |
| vec_o | output | 16 | Word address of the selected vector entry |
| prio_o | output | 4 | Selected priority level |
| gie_o | output | 1 | Current global enable |

## Verification
The hardest situation to reach from the ports is a new, higher request arriving while the acknowledge is held. This must not move the frozen vector, and the release edge must then pick that request up with the global enable already cleared. The stimulus reaches it in a fixed order. It raises a maskable request with the global enable set and asserts the acknowledge. While the acknowledge is held, it raises a level-10 flag and then an enabled level-14 flag. It checks that the vector stays put, then drops the acknowledge and expects level 14, with level 3 now blocked. Sweeps over every level, every group bit and every enable/global-enable combination cover the gating classes, and a sweep over all level pairs covers the priority order.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PEND,
        ST_HOLD
    } pvic_state_e;

    typedef enum logic [1:0] {
        CLS_RESET,
        CLS_NMK,
        CLS_MASK
    } pvic_class_e;

    // Gating class of a level given the level count and the lowest (non)-maskable level
    function automatic pvic_class_e class_of(input int lvl, input int n_lvl, input int nmk_lo);
        if (lvl == n_lvl - 1) begin
            return CLS_RESET;
        end else if (lvl >= nmk_lo) begin
            return CLS_NMK;
        end
        return CLS_MASK;
    endfunction

endpackage

// File: rtl/pvic_group_gate.sv
module pvic_group_gate
    import pvic_pkg::*;
#(
    parameter int          GRP_W = 8,
    parameter pvic_class_e CLS   = CLS_MASK
) (
    input  logic [GRP_W-1:0] flag_i,
    input  logic [GRP_W-1:0] en_i,
    input  logic             gie_i,
    output logic             req_o
);

    logic any_flag;
    logic any_enabled;

    assign any_flag    = |flag_i;
    assign any_enabled = |(flag_i & en_i);

    generate
        if (CLS == CLS_RESET) begin : g_reset
            assign req_o = any_flag;
        end else if (CLS == CLS_NMK) begin : g_nmk
            assign req_o = any_enabled;
        end else begin : g_mask
            assign req_o = any_enabled & gie_i;
        end
    endgenerate

endmodule

// File: rtl/pvic_req_gather.sv
module pvic_req_gather
    import pvic_pkg::*;
#(
    parameter int N_LVL  = 16,
    parameter int GRP_W  = 8,
    parameter int NMK_LO = 12
) (
    input  logic [N_LVL*GRP_W-1:0] flag_i,
    input  logic [N_LVL*GRP_W-1:0] en_i,
    input  logic                   gie_i,
    output logic [N_LVL-1:0]       req_o
);

    generate
        for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
            pvic_group_gate #(
                .GRP_W (GRP_W),
                .CLS   (class_of(l, N_LVL, NMK_LO))
            ) u_gate (
                .flag_i (flag_i[l*GRP_W +: GRP_W]),
                .en_i   (en_i[l*GRP_W +: GRP_W]),
                .gie_i  (gie_i),
                .req_o  (req_o[l])
            );
        end
    endgenerate

endmodule

// File: rtl/pvic_prio_enc.sv
module pvic_prio_enc #(
    parameter int N_LVL = 16,
    localparam int IDX_W = $clog2(N_LVL)
) (
    input  logic [N_LVL-1:0] req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Ascending scan: the last hit, i.e. the highest level, wins
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N_LVL; i++) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pvic_ctrl.sv
module pvic_ctrl
    import pvic_pkg::*;
#(
    parameter int          N_LVL    = 16,
    parameter int          GRP_W    = 8,
    parameter int          NMK_LO   = 12,
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] VEC_BASE = 16'hFFE0,
    localparam int         IDX_W    = $clog2(N_LVL),
    localparam int         FLAG_W   = N_LVL * GRP_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FLAG_W-1:0] flag_i,
    input  logic [FLAG_W-1:0] en_i,
    input  logic              gie_wr_i,
    input  logic              gie_wdata_i,
    input  logic              ack_i,
    output logic              irq_o,
    output logic [ADDR_W-1:0] vec_o,
    output logic [IDX_W-1:0]  prio_o,
    output logic              gie_o
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(VEC_BASE);

    function automatic logic [ADDR_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        return BASE + (ADDR_W'(idx) << 1);
    endfunction

    pvic_state_e      state_q, state_d;
    logic [N_LVL-1:0] req;
    logic             any_req;
    logic [IDX_W-1:0] win_idx;
    logic             take;
    logic             upd;
    logic             gie_q;
    logic             irq_q;
    logic [IDX_W-1:0] prio_q;
    logic [ADDR_W-1:0] vec_q;

    pvic_req_gather #(
        .N_LVL  (N_LVL),
        .GRP_W  (GRP_W),
        .NMK_LO (NMK_LO)
    ) u_gather (
        .flag_i (flag_i),
        .en_i   (en_i),
        .gie_i  (gie_q),
        .req_o  (req)
    );

    pvic_prio_enc #(
        .N_LVL (N_LVL)
    ) u_enc (
        .req_i (req),
        .any_o (any_req),
        .idx_o (win_idx)
    );

    // take: PEND -> HOLD; upd: outputs re-resolve this edge
    assign take = (state_q == ST_PEND) && ack_i;
    assign upd  = !take && !((state_q == ST_HOLD) && ack_i);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = any_req ? ST_PEND : ST_IDLE;        // raise
            ST_PEND: begin
                if (ack_i)         state_d = ST_HOLD;              // take
                else if (!any_req) state_d = ST_IDLE;              // drop
                else               state_d = ST_PEND;
            end
            ST_HOLD: begin
                if (ack_i)        state_d = ST_HOLD;               // keep
                else if (any_req) state_d = ST_PEND;               // release
                else              state_d = ST_IDLE;               // release
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // output and global-enable registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            irq_q  <= 1'b0;
            prio_q <= '0;
            vec_q  <= BASE;
            gie_q  <= 1'b0;
        end else begin
            if (take)          gie_q <= 1'b0;
            else if (gie_wr_i) gie_q <= gie_wdata_i;

            if (take) begin
                irq_q <= 1'b0;
            end else if (upd) begin
                irq_q <= any_req;
                if (any_req) begin
                    prio_q <= win_idx;
                    vec_q  <= vec_of(win_idx);
                end
            end
        end
    end

    assign irq_o  = irq_q;
    assign vec_o  = vec_q;
    assign prio_o = prio_q;
    assign gie_o  = gie_q;

    AST_VEC_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_o == BASE + (ADDR_W'(prio_o) << 1));                                   // R2
    AST_TOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd && (|flag_i[FLAG_W-1 -: GRP_W])) |=> (prio_o == IDX_W'(N_LVL-1)) && irq_o); // R3
    AST_ACK_CLR_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PEND && ack_i) |=> !gie_o && !irq_o);                       // R9
    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HOLD && ack_i) |=> $stable(vec_o) && $stable(prio_o));      // R10
    AST_IDLE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd && !(|req)) |=> !irq_o && $stable(vec_o));                            // R11

endmodule

// File: tb/tb_pvic_ctrl.sv
module tb_pvic_ctrl;

    localparam int N_LVL = 16;
    localparam int GRP_W = 8;
    localparam int FLAG_W = N_LVL * GRP_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [FLAG_W-1:0] flag = '0;
    logic [FLAG_W-1:0] en = '0;
    logic              gie_wr = 1'b0;
    logic              gie_wdata = 1'b0;
    logic              ack = 1'b0;
    logic              irq;
    logic [15:0]       vec;
    logic [3:0]        prio;
    logic              gie;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [3:0] exp_prio = 4'd0;

    always #5 clk = ~clk;

    pvic_ctrl dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .flag_i      (flag),
        .en_i        (en),
        .gie_wr_i    (gie_wr),
        .gie_wdata_i (gie_wdata),
        .ack_i       (ack),
        .irq_o       (irq),
        .vec_o       (vec),
        .prio_o      (prio),
        .gie_o       (gie)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] vaddr(input logic [3:0] p);
        return 16'hFFE0 + 16'(p) * 16'd2;
    endfunction

    task automatic write_gie(input logic v);
        @(negedge clk);
        gie_wr = 1'b1;
        gie_wdata = v;
        @(negedge clk);
        gie_wr = 1'b0;
    endtask

    task automatic settle;
        @(posedge clk);
        #1;
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 irq", 32'(irq), 0);
        chk("R1 vec", 32'(vec), 32'h0000FFE0);
        chk("R1 prio", 32'(prio), 0);
        chk("R1 gie", 32'(gie), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R12 write of global enable
        write_gie(1'b1);
        chk("R12 gie set", 32'(gie), 1);
        write_gie(1'b0);
        chk("R12 gie clear", 32'(gie), 0);

        // R4 R5 R6 R7 R2: every level, every group bit, all enable/gie combinations
        for (int g = 0; g < 2; g++) begin
            write_gie(g[0]);
            for (int l = 0; l < N_LVL; l++) begin
                for (int b = 0; b < GRP_W; b++) begin
                    for (int e = 0; e < 2; e++) begin
                        logic want;
                        @(negedge clk);
                        flag = '0;
                        en = '0;
                        flag[l*GRP_W + b] = 1'b1;
                        en[l*GRP_W + b] = e[0];
                        // other enables in the group set, must not matter
                        for (int k = 0; k < GRP_W; k++) if (k != b) en[l*GRP_W + k] = 1'b1;
                        if (l == 15)      want = 1'b1;               // R4
                        else if (l >= 12) want = e[0];               // R5
                        else              want = e[0] & g[0];        // R6
                        settle();
                        if (want) exp_prio = 4'(l);
                        chk(l == 15 ? "R4 irq" : (l >= 12 ? "R5 irq" : "R6 irq"), 32'(irq), 32'(want));
                        chk("R7 prio", 32'(prio), 32'(exp_prio));
                        chk("R2 vec", 32'(vec), 32'(vaddr(exp_prio)));
                    end
                end
            end
        end

        // R3 priority over all level pairs, everything enabled
        write_gie(1'b1);
        for (int a = 0; a < N_LVL; a++) begin
            for (int b = 0; b < N_LVL; b++) begin
                @(negedge clk);
                en = '1;
                flag = '0;
                flag[a*GRP_W + (a % GRP_W)] = 1'b1;
                flag[b*GRP_W + (b % GRP_W)] = 1'b1;
                settle();
                exp_prio = 4'((a > b) ? a : b);
                chk("R3 prio", 32'(prio), 32'(exp_prio));
                chk("R3 irq", 32'(irq), 1);
            end
        end

        // R11 no request: irq low, vector held; R8 registered latency
        @(negedge clk);
        flag = '0;
        #1;
        chk("R8 no comb change", 32'(irq), 1);
        settle();
        chk("R11 irq", 32'(irq), 0);
        chk("R11 vec hold", 32'(vec), 32'(vaddr(exp_prio)));
        chk("R11 prio hold", 32'(prio), 32'(exp_prio));

        // R9 ack in IDLE ignored
        @(negedge clk);
        ack = 1'b1;
        settle();
        chk("R9 idle ack gie", 32'(gie), 1);
        @(negedge clk);
        ack = 1'b0;

        // R9 R10 acknowledge sequence
        @(negedge clk);
        en = '1;
        flag = '0;
        flag[3*GRP_W + 6] = 1'b1;
        settle();
        chk("R7 bit6 prio", 32'(prio), 3);
        chk("R9 pend irq", 32'(irq), 1);
        @(negedge clk);
        ack = 1'b1;
        gie_wr = 1'b1;
        gie_wdata = 1'b1;
        flag[10*GRP_W + 7] = 1'b1;
        settle();
        chk("R9 gie cleared", 32'(gie), 0);
        chk("R9 irq dropped", 32'(irq), 0);
        chk("R10 prio frozen", 32'(prio), 3);
        @(negedge clk);
        gie_wr = 1'b0;
        flag[14*GRP_W + 1] = 1'b1;
        settle();
        chk("R10 prio frozen 2", 32'(prio), 3);
        chk("R10 vec frozen", 32'(vec), 32'(vaddr(4'd3)));
        @(negedge clk);
        ack = 1'b0;
        settle();
        chk("R10 release prio", 32'(prio), 14);
        chk("R10 release irq", 32'(irq), 1);
        @(negedge clk);
        flag[14*GRP_W + 1] = 1'b0;
        settle();
        chk("R6 blocked after ack", 32'(irq), 0);

        done = 1'b1;
        report();
    end

endmodule